// File: doc/BRIEF.md
# 10-bit Pulse-Width Modulator

This block drives one pulse-width modulated output from a fast timer tick. Software, or a neighbouring controller, writes a 10-bit period and a 10-bit duty value through a byte-wide write port. Each value has a low byte of its own, and the top two bits of both values share a third register. The output spends `duty` ticks of every `period` ticks in its active state. A polarity input decides whether the active state is a high level or a low level.

The tick is either every system clock or every second system clock. A resolution select masks the period and duty down to 9, 8 or 7 bits, so each step halves the period reached by a full-scale value. New period, duty and resolution values are held in a staging set and reach the counter only when a period ends. The pulse train therefore never shows a truncated or stretched cycle. While the block is disabled, its output sits at the inactive level and its counter rests at zero.

Top module: `pwm10_gen`

## Requirements
- R1: After synchronous reset, the output shows the inactive level for the applied polarity, and the staged and active period and duty are zero.
- R2: A write with `wr_sel`=0 sets period bits [7:0], `wr_sel`=1 sets duty bits [7:0], and `wr_sel`=2 sets period bits [9:8] from data bits [1:0] and duty bits [9:8] from data bits [3:2]. A write with `wr_sel`=3 is ignored.
- R3: The counter steps 0,1,…,P-1 on each tick and then wraps to 0, so one output period lasts P ticks (one tick when P is 0 or 1). The output is active while the count is below the duty value D.
- R4: With `tick_sel`=0 a tick occurs on every enabled clock. With `tick_sel`=1 a tick occurs on every second enabled clock, so the output period is doubled.
- R5: With `polarity`=1 the active level is high. With `polarity`=0 the active level is low.
- R6: Written period and duty values, and the resolution select, take effect only when the counter wraps to 0. A change made mid-period leaves the rest of that period unchanged.
- R7: With D=0 the output is always inactive. With D≥P (P≥1) the output is always active.
- R8: While `en`=0, the output is at the inactive level and the counter is held at 0. The staged values are copied into the active set every clock.
- R9: `res_sel`=0,1,2,3 selects 10-, 9-, 8- or 7-bit resolution. Both period and duty are masked to that many low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| tick_sel | input | 1 | 0: tick every clock, 1: tick every second clock |
| res_sel | input | 2 | Resolution reduction steps (0 to 3) |
| polarity | input | 1 | 1: active level high, 0: active level low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| pwm_o | output | 1 | Modulated output |

## Verification
The output is decoded combinationally from the registered count, the active settings, `en` and `polarity`. A change of `en` or `polarity` therefore shows in the same cycle, and the count moves one clock edge after each tick. A write lands in the staging set at the next edge and reaches the output only on the first tick after the following wrap. The bench drives inputs 1 ns after the rising edge and steps its behavioural model on the same rising edge. It compares `pwm_o` against the model at every falling edge, so each result is sampled in the cycle it becomes due. Directed checks count active cycles over whole numbers of periods after a settling time. This makes them independent of the phase at which a setting took effect.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
    localparam int CNT_W  = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = CNT_W - BYTE_W;
    localparam int RES_W  = 2;

    typedef enum logic [1:0] {
        SEL_PER_LO  = 2'd0,
        SEL_DUTY_LO = 2'd1,
        SEL_HI      = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [RES_W-1:0] res;
    } pwm_cfg_t;

    function automatic logic [CNT_W-1:0] res_mask(input logic [RES_W-1:0] r);
        return {CNT_W{1'b1}} >> r;
    endfunction
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  per_stg,
    output logic [CNT_W-1:0]  duty_stg
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_stg  <= '0;
            duty_stg <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PER_LO:  per_stg[BYTE_W-1:0]  <= wr_data;
                SEL_DUTY_LO: duty_stg[BYTE_W-1:0] <= wr_data;
                SEL_HI: begin
                    per_stg[CNT_W-1:BYTE_W]  <= wr_data[HI_W-1:0];
                    duty_stg[CNT_W-1:BYTE_W] <= wr_data[2*HI_W-1:HI_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm10_prescale.sv
module pwm10_prescale (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick_sel,
    output logic tick
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= en & tick_sel & ~half_q;
    end

    assign tick = en & (~tick_sel | half_q);
endmodule

// File: rtl/pwm10_core.sv
module pwm10_core
    import pwm10_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  pwm_cfg_t         cfg_next,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_eff,
    output logic [CNT_W-1:0] duty_eff,
    output logic             active
);
    pwm_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             wrap;

    assign per_eff  = cfg_q.per  & res_mask(cfg_q.res);
    assign duty_eff = cfg_q.duty & res_mask(cfg_q.res);
    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
    assign wrap     = cnt_inc >= {1'b0, per_eff};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cfg_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
            cfg_q <= cfg_next;
        end else if (tick) begin
            if (wrap) begin
                cnt_q <= '0;
                cfg_q <= cfg_next;
            end else begin
                cnt_q <= cnt_inc[CNT_W-1:0];
            end
        end
    end

    assign cnt    = cnt_q;
    assign active = cnt_q < duty_eff;
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick_sel,
    input  logic [RES_W-1:0]  res_sel,
    input  logic              polarity,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              pwm_o
);
    logic [CNT_W-1:0] per_stg, duty_stg;
    logic [CNT_W-1:0] cnt_w, per_eff_w, duty_eff_w;
    logic             tick, active;
    pwm_cfg_t         cfg_next;

    pwm10_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .per_stg(per_stg), .duty_stg(duty_stg)
    );

    pwm10_prescale u_pre (
        .clk(clk), .rst(rst), .en(en), .tick_sel(tick_sel), .tick(tick)
    );

    assign cfg_next = '{per: per_stg, duty: duty_stg, res: res_sel};

    pwm10_core u_core (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .cfg_next(cfg_next),
        .cnt(cnt_w), .per_eff(per_eff_w), .duty_eff(duty_eff_w),
        .active(active)
    );

    assign pwm_o = en ? (polarity ? active : ~active) : ~polarity;
endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk
    import pwm10_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pol,
    input logic             pwm_o,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_eff,
    input logic [CNT_W-1:0] duty_eff
);
    a_r8_idle_counter_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0 || en));

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt == '0 || cnt < per_eff));

    a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> (cnt == '0 || cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    a_r6_settings_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && cnt != '0) |-> ($stable(per_eff) && $stable(duty_eff)));

    a_r7_zero_duty_inactive: assert property (@(posedge clk) disable iff (rst)
        (en && duty_eff == '0) |-> (pwm_o == ~pol));

    a_r7_full_duty_active: assert property (@(posedge clk) disable iff (rst)
        (en && per_eff != '0 && duty_eff >= per_eff) |-> (pwm_o == pol));
endmodule

bind pwm10_gen pwm10_gen_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .pol(polarity), .pwm_o(pwm_o),
    .cnt(cnt_w), .per_eff(per_eff_w), .duty_eff(duty_eff_w)
);

// File: tb/tb_pwm10_gen.sv
`timescale 1ns/1ps
module tb_pwm10_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, tick_sel = 1'b0, polarity = 1'b1, wr_en = 1'b0;
    logic [1:0] res_sel = 2'd0, wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_o;

    int    n_checks = 0, n_fails = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // behavioural reference state
    int m_cnt, m_per, m_duty, m_res, s_per, s_duty;
    bit m_pre, tk;

    always #2 clk = ~clk;

    pwm10_gen dut (
        .clk(clk), .rst(rst), .en(en), .tick_sel(tick_sel), .res_sel(res_sel),
        .polarity(polarity), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwm_o(pwm_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_res = 0;
            s_per = 0; s_duty = 0; m_pre = 0;
        end else begin
            tk = !tick_sel || m_pre;
            if (!en) begin
                m_cnt = 0; m_per = s_per; m_duty = s_duty; m_res = res_sel; m_pre = 0;
            end else begin
                if (tk) begin
                    if (m_cnt + 1 >= (m_per & (1023 >> m_res))) begin
                        m_cnt = 0; m_per = s_per; m_duty = s_duty; m_res = res_sel;
                    end else m_cnt = m_cnt + 1;
                end
                m_pre = tick_sel ? !m_pre : 1'b0;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: s_per  = (s_per  & 'h300) | wr_data;
                    2'd1: s_duty = (s_duty & 'h300) | wr_data;
                    2'd2: begin
                        s_per  = (s_per  & 'hFF) | ((wr_data & 3) << 8);
                        s_duty = (s_duty & 'hFF) | (((wr_data >> 2) & 3) << 8);
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            bit act, exp_o;
            act   = m_cnt < (m_duty & (1023 >> m_res));
            exp_o = en ? (polarity ? act : !act) : !polarity;
            check(cur_req, pwm_o, exp_o);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic measure(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        @(posedge clk); #1;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int hi;
        step(4);
        rst = 1'b0;
        step(1);
        cur_req = "R1";
        check("R1", pwm_o, 0);
        polarity = 1'b0; #1;
        check("R1", pwm_o, 1);
        polarity = 1'b1;
        cmp_on = 1'b1;

        // R2/R3: period 10, duty 4; a write to select 3 must change nothing
        cur_req = "R2";
        wr(2'd0, 8'd10); wr(2'd1, 8'd4); wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
        en = 1'b1;
        cur_req = "R3";
        step(20);
        measure(30, hi); check("R3", hi, 12);

        // R2: upper bits, period 0x10A, duty 0x104
        cur_req = "R2";
        wr(2'd2, 8'h05);
        step(300);
        measure(266, hi); check("R2", hi, 260);

        // R4: half-rate tick
        cur_req = "R4";
        wr(2'd2, 8'h00);
        tick_sel = 1'b1;
        step(600);
        measure(60, hi); check("R4", hi, 24);

        // R5: active low
        cur_req = "R5";
        polarity = 1'b0;
        step(5);
        measure(60, hi); check("R5", hi, 36);
        polarity = 1'b1;
        tick_sel = 1'b0;

        // R6: mid-period change, compared cycle by cycle
        cur_req = "R6";
        step(23);
        wr(2'd1, 8'd7);
        step(3);
        wr(2'd0, 8'd12);
        step(40);
        measure(36, hi); check("R6", hi, 21);

        // R7: duty 0, duty above period, duty equal to period
        cur_req = "R7";
        wr(2'd0, 8'd10); wr(2'd1, 8'd0);
        step(25);
        measure(30, hi); check("R7", hi, 0);
        wr(2'd1, 8'd20);
        step(25);
        measure(30, hi); check("R7", hi, 30);
        wr(2'd1, 8'd10);
        step(25);
        measure(30, hi); check("R7", hi, 30);

        // R8: disabled output and staging pass-through
        cur_req = "R8";
        wr(2'd1, 8'd3);
        en = 1'b0;
        step(2);
        check("R8", pwm_o, 0);
        polarity = 1'b0; #1;
        check("R8", pwm_o, 1);
        polarity = 1'b1;
        wr(2'd1, 8'd5);
        step(2);
        en = 1'b1;
        measure(30, hi); check("R8", hi, 15);

        // R9: resolution reduction, period 0x3FF, duty 0x080
        cur_req = "R9";
        wr(2'd0, 8'hFF); wr(2'd1, 8'h80); wr(2'd2, 8'h03);
        res_sel = 2'd2;
        step(600);
        measure(510, hi); check("R9", hi, 256);
        res_sel = 2'd3;
        step(300);
        measure(254, hi); check("R9", hi, 0);
        res_sel = 2'd0;
        step(1100);
        measure(1023, hi); check("R9", hi, 128);

        cmp_on = 1'b0;
        summary();
        $finish;
    end
endmodule